// File: doc/BRIEF.md
# Event Flag Status Register with AND-Masked Clearing

This block keeps the interrupt status bits of a timekeeping subsystem: one sticky flag each for the periodic minute/second tick, the watchdog, the second timestamp channel, the alarm and the countdown timer. Each source pulses its strobe for one clock cycle, and the matching flag then stays set until it is cleared. A combined interrupt request is raised while any flag is set.

Software clears flags by writing the register. The write data is ANDed into the flags, so a bit written as 0 is cleared and a bit written as 1 keeps its value. Software can therefore clear one flag without reading the others first, and without the risk of losing an event that arrives between a read and a write. The watchdog flag cannot be changed by a write. The three low bits are plain control storage that takes the written value. The register contents can be read on the read port in every cycle.

Top module: `evt_flag_reg`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rd_data` is 8'h00 and `irq` is 0.
- R2: A high `evt_set[i]` at a clock edge sets register bit i+3 after that edge. The strobes map as follows: `evt_set[4]` is the tick flag (bit 7), `evt_set[3]` the watchdog flag (bit 6), `evt_set[2]` the timestamp-2 flag (bit 5), `evt_set[1]` the alarm flag (bit 4) and `evt_set[0]` the countdown flag (bit 3).
- R3: On a write (`wr_en` high), each writable flag (bits 7, 5, 4 and 3) takes its old value ANDed with the matching `wr_data` bit, so a 0 in that position clears the flag.
- R4: A 1 written to a flag position leaves that flag unchanged. Writing the same value again has no further effect.
- R5: The watchdog flag (bit 6) ignores `wr_data` and `wr_en`. Once set, it stays set until reset.
- R6: If a flag's strobe and a write clearing that flag fall in the same cycle, the flag is 1 after the edge.
- R7: Bits 2:0 load `wr_data[2:0]` on a write and hold their value otherwise.
- R8: `irq` is 1 exactly when at least one of bits 7:3 of `rd_data` is 1. It changes in the same cycle as `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: flag positions AND-masked, bits 2:0 stored |
| evt_set | input | 5 | One-cycle set strobes from the event sources |
| rd_data | output | 8 | Current register contents |
| irq | output | 1 | OR of all flags |

## Verification
A flag's set strobe and a write can hit the same flag in the same cycle. That write may clear the flag, or it may be a keep-write that carries a 1 in that position. The bench provokes both cases by driving a strobe together with `wr_en`. One case uses a mask that clears every writable flag. Another clears a neighbouring flag while the strobed one is set. After that edge, the strobed flag must read 1, the neighbour must read 0 and the control bits must hold the written value.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;
    localparam int FLAG_W   = 5;                 // number of event flags
    localparam int CTRL_W   = 3;                 // number of plain control bits
    localparam int REG_W    = FLAG_W + CTRL_W;   // register width
    localparam int WDOG_IDX = 3;                 // flag index of the read-only watchdog flag

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [CTRL_W-1:0] ctrl;
    } stat_reg_t;
endpackage

// File: rtl/evt_flag_next.sv
// Next-value logic for one sticky flag: a set strobe wins over a clearing write.
module evt_flag_next #(
    parameter bit READ_ONLY = 1'b0
) (
    input  logic cur,
    input  logic set,
    input  logic wr_en,
    input  logic wr_bit,
    output logic nxt
);
    logic wr_clr;
    logic clr;

    always_comb begin
        wr_clr = wr_en & ~wr_bit;
        clr    = READ_ONLY ? 1'b0 : wr_clr;
        nxt    = set | (cur & ~clr);
    end
endmodule

// File: rtl/evt_ctrl_next.sv
// Next-value logic for the plain control bits: direct load on write.
module evt_ctrl_next #(
    parameter int W = 3
) (
    input  logic [W-1:0] cur,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] nxt
);
    always_comb begin
        nxt = wr_en ? wr_val : cur;
    end
endmodule

// File: rtl/evt_flag_reg.sv
module evt_flag_reg
    import evt_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] evt_set,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);
    stat_reg_t         state_d, state_q;
    logic [FLAG_W-1:0] flag_nxt;
    logic [CTRL_W-1:0] ctrl_nxt;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        evt_flag_next #(
            .READ_ONLY(i == WDOG_IDX)
        ) u_flag (
            .cur    (state_q.flags[i]),
            .set    (evt_set[i]),
            .wr_en  (wr_en),
            .wr_bit (wr_data[CTRL_W+i]),
            .nxt    (flag_nxt[i])
        );
    end

    evt_ctrl_next #(
        .W(CTRL_W)
    ) u_ctrl (
        .cur    (state_q.ctrl),
        .wr_en  (wr_en),
        .wr_val (wr_data[CTRL_W-1:0]),
        .nxt    (ctrl_nxt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flags = flag_nxt;
        state_d.ctrl  = ctrl_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_data = state_q;
    assign irq     = |state_q.flags;
endmodule

// File: rtl/evt_flag_reg_chk.sv
module evt_flag_reg_chk
    import evt_flag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [FLAG_W-1:0] evt_set,
    input logic [REG_W-1:0]  rd_data,
    input logic              irq
);
    // R2: countdown strobe sets bit 3
    a_r2_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set[0] |=> rd_data[3]);

    // R3: write with 0 in tick position and no tick strobe clears bit 7
    a_r3_and_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7] && !evt_set[4]) |=> !rd_data[7]);

    // R4: write with 1 in alarm position keeps bit 4 when no strobe
    a_r4_keep_one: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[4] && !evt_set[1]) |=> (rd_data[4] == $past(rd_data[4])));

    // R5: watchdog flag changes only through its strobe
    a_r5_wdog_ro: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_set[WDOG_IDX] |=> (rd_data[6] == $past(rd_data[6])));

    // R6: set beats clear on timestamp-2 flag
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set[2] && wr_en && !wr_data[5]) |=> rd_data[5]);

    // R7: control bits load written value
    a_r7_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[2:0] == $past(wr_data[2:0])));

    // R8: irq only with a flag set
    a_r8_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[7:3] != '0));
endmodule

bind evt_flag_reg evt_flag_reg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .evt_set (evt_set),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/evt_flag_reg_tb.sv
module evt_flag_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [4:0] evt_set = '0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    evt_flag_reg u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .evt_set (evt_set),
        .rd_data (rd_data),
        .irq     (irq)
    );

    typedef struct packed {
        logic       we;
        logic [7:0] wd;
        logic [4:0] ev;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 5'b10000, 8'h80, 4'd2},  // R2 tick
        '{1'b0, 8'h00, 5'b00001, 8'h88, 4'd2},  // R2 countdown
        '{1'b0, 8'h00, 5'b01000, 8'hC8, 4'd2},  // R2 watchdog
        '{1'b1, 8'hFF, 5'b00000, 8'hCF, 4'd4},  // R4 all ones keep, ctrl loads
        '{1'b1, 8'hFF, 5'b00000, 8'hCF, 4'd4},  // R4 repeat no effect
        '{1'b1, 8'h7F, 5'b00000, 8'h4F, 4'd3},  // R3 clear tick only
        '{1'b1, 8'h00, 5'b00000, 8'h40, 4'd5},  // R5 watchdog survives zero write
        '{1'b0, 8'h00, 5'b00110, 8'h70, 4'd2},  // R2 ts2 + alarm
        '{1'b1, 8'h05, 5'b00010, 8'h55, 4'd6},  // R6 alarm set beats clear
        '{1'b1, 8'hB2, 5'b00000, 8'h52, 4'd7},  // R7 ctrl = 010
        '{1'b0, 8'h00, 5'b00000, 8'h52, 4'd7},  // R7 hold without write
        '{1'b1, 8'h02, 5'b10000, 8'hC2, 4'd6}   // R6 tick set wins, alarm cleared
    };

    task automatic check(input string req, input logic [7:0] exp_rd);
        logic exp_irq;
        exp_irq = |exp_rd[7:3];
        checks++;
        if (rd_data !== exp_rd || irq !== exp_irq) begin
            failures++;
            $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     req, rd_data, irq, exp_rd, exp_irq);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] wd, input logic [4:0] ev);
        @(negedge clk);
        wr_en = we; wr_data = wd; evt_set = ev;
        @(posedge clk);
        #3;
        wr_en = 1'b0; wr_data = '0; evt_set = '0;
        #2;
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    failures++;
                    $display("FAIL watchdog: run hung");
                    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                    $finish;
                end
            end
        join_none

        #5;
        check("R1", 8'h00);             // R1 in reset
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #5;
        check("R1", 8'h00);             // R1 first cycle after reset

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].we, VECS[i].wd, VECS[i].ev);
            check($sformatf("R%0d", VECS[i].req), VECS[i].exp);
        end

        // R1: reset mid-run clears everything, including the watchdog flag
        @(negedge clk); rst_n = 1'b0;
        #5;
        check("R1", 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R8: control bits alone do not raise irq
        step(1'b1, 8'h07, 5'b00000);
        check("R8", 8'h07);
        // R8: a single flag raises irq together with rd_data
        step(1'b0, 8'h00, 5'b00001);
        check("R8", 8'h0F);
        // R3: clearing countdown drops irq
        step(1'b1, 8'hF7, 5'b00000);
        check("R3", 8'h07);
        // R5: ones in watchdog position on write do not set it
        step(1'b1, 8'h40, 5'b00000);
        check("R5", 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule